// File: doc/BRIEF.md
# Composite Sync Classifier with Burst Gate Timer

This block is the timing core of a composite video encoder. It runs from a clock at four times the colour subcarrier. It merges a horizontal and a vertical sync input into one active-low composite sync, and re-times that sync on every second clock. It then measures how many clocks each sync pulse stays low.

A pulse of normal line-sync width schedules a burst/clamp gate window a fixed number of clocks after the falling edge of the sync. A pulse that is too long is taken as vertical sync. It suppresses the gate and raises a vertical-blanking-mode flag. A pulse that is too short is dropped as a glitch.

When the gate closes, a one-clock strobe is issued so that downstream line-rate clocks can be realigned during the burst interval. A single select input chooses between the 525-line (NTSC) and 625-line (PAL) count constants.

Top module: `vsync_gate_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `csync_out` is 1 and `burst_gate`, `vblank_mode` and `gate_end` are 0.
- R2: `csync_out` equals XNOR(`hsync_in`, `vsync_in`) once the inputs have been stable for 6 clocks. With `vsync_in` held at 1, `csync_out` follows `hsync_in`.
- R3: `csync_out` changes only on every second clock, so any two of its transitions are an even number of cycles apart. An input low interval of even length L gives a `csync_out` low interval of exactly L cycles.
- R4: With `std_pal`=0, a low width W (cycles `csync_out` stays low) in 58..76 makes `burst_gate` rise exactly 79 cycles after the first low cycle of `csync_out`.
- R5: The gate stays high for exactly 36 cycles with `std_pal`=0 and exactly 44 cycles with `std_pal`=1.
- R6: `gate_end` is high for exactly one cycle: the first cycle in which `burst_gate` is low again.
- R7: A width above the line range opens no gate. It also sets `vblank_mode` to 1 from the second cycle after `csync_out` returns high. The width counter saturates and never wraps.
- R8: A width below the line range opens no gate and leaves `vblank_mode` unchanged.
- R9: A width inside the line range clears `vblank_mode` to 0.
- R10: With `std_pal`=1 the line range is 72..94 and the gate delay is 98 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the subcarrier |
| rst | input | 1 | Synchronous active-high reset |
| std_pal | input | 1 | 0 selects 525-line constants, 1 selects 625-line constants |
| hsync_in | input | 1 | Horizontal or composite sync, active low |
| vsync_in | input | 1 | Vertical sync, active low; tie high for composite input |
| csync_out | output | 1 | Re-timed composite sync, active low |
| burst_gate | output | 1 | Burst/clamp gate window, active high |
| vblank_mode | output | 1 | Set by an over-long sync pulse |
| gate_end | output | 1 | One-clock strobe when the gate closes |

## Verification
The bench builds the block with its default parameters: a 10-bit width counter, a two-flop synchronizer, and the two standards' delay, length and range constants. These values put both range limits and the clock pair on either side of each limit within reach in a few hundred cycles per line. Field pulses up to several hundred clocks also exercise the path where the sync is still low when the gate delay has already passed. Switching `std_pal` between lines checks that the constants follow the select without a reset.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    PW_SHORT = 2'd0,
    PW_LINE  = 2'd1,
    PW_LONG  = 2'd2
  } pw_class_e;
endpackage

// File: rtl/vsg_sync_front.sv
module vsg_sync_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_i,
  input  logic vsync_i,
  output logic cs_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] h_sr, v_sr;
  logic phase_q, cs_q, cs_d;
  logic merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sr <= '1;
      v_sr <= '1;
    end else begin
      h_sr <= {h_sr[STAGES-2:0], hsync_i};
      v_sr <= {v_sr[STAGES-2:0], vsync_i};
    end
  end

  // Equal inputs give high; any single low input gives low.
  assign merged = ~(h_sr[STAGES-1] ^ v_sr[STAGES-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      cs_q    <= 1'b1;
      cs_d    <= 1'b1;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) cs_q <= merged;
      cs_d <= cs_q;
    end
  end

  assign cs_o   = cs_q;
  assign fall_o = cs_d & ~cs_q;
  assign rise_o = ~cs_d & cs_q;

  assert_halfrate_R3: assert property (@(posedge clk) disable iff (rst)
    !phase_q |=> $stable(cs_q));
endmodule

// File: rtl/vsg_width_meas.sv
module vsg_width_meas
  import vsg_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          fall_i,
  input  logic          rise_i,
  input  logic [CW-1:0] hmin_i,
  input  logic [CW-1:0] hmax_i,
  output logic          line_p_o,
  output logic          vblank_o
);
  logic [CW-1:0] cnt;
  logic          line_p_q, vblank_q;
  pw_class_e     cls;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (fall_i) begin
      cnt <= CW'(1);
    end else if (!cs_i && cnt != '1) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_comb begin
    if (cnt < hmin_i)      cls = PW_SHORT;
    else if (cnt > hmax_i) cls = PW_LONG;
    else                   cls = PW_LINE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_p_q <= 1'b0;
      vblank_q <= 1'b0;
    end else begin
      line_p_q <= rise_i && (cls == PW_LINE);
      if (rise_i && cls == PW_LONG)      vblank_q <= 1'b1;
      else if (rise_i && cls == PW_LINE) vblank_q <= 1'b0;
    end
  end

  assign line_p_o = line_p_q;
  assign vblank_o = vblank_q;

  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_i && !fall_i && cnt == '1) |=> cnt == '1);
  assert_vblank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(vblank_q));
endmodule

// File: rtl/vsg_gate_timer.sv
module vsg_gate_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_i,
  input  logic          line_p_i,
  input  logic [CW-1:0] dly_i,
  input  logic [CW-1:0] len_i,
  output logic          gate_o,
  output logic          end_o
);
  logic [CW-1:0] since, open_at, close_at;
  logic          armed, gate_q, end_q, arm_now;

  assign open_at  = dly_i - CW'(1);
  assign close_at = dly_i + len_i - CW'(1);
  assign arm_now  = armed | line_p_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      since  <= '0;
      armed  <= 1'b0;
      gate_q <= 1'b0;
      end_q  <= 1'b0;
    end else if (fall_i) begin
      since  <= CW'(1);
      armed  <= 1'b0;
      gate_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      if (since != '1) since <= since + CW'(1);
      end_q <= 1'b0;
      if (!gate_q && arm_now && since == open_at) begin
        gate_q <= 1'b1;
        armed  <= 1'b0;
      end else begin
        if (line_p_i) armed <= 1'b1;
        if (gate_q && since == close_at) begin
          gate_q <= 1'b0;
          end_q  <= 1'b1;
        end
      end
    end
  end

  assign gate_o = gate_q;
  assign end_o  = end_q;

  assert_end_single_R6: assert property (@(posedge clk) disable iff (rst)
    end_q |=> !end_q);
endmodule

// File: rtl/vsync_gate_ctl.sv
module vsync_gate_ctl #(
  parameter int CW            = 10,
  parameter int SYNC_STAGES   = 2,
  parameter int NTSC_GATE_DLY = 79,
  parameter int NTSC_GATE_LEN = 36,
  parameter int NTSC_HMIN     = 58,
  parameter int NTSC_HMAX     = 76,
  parameter int PAL_GATE_DLY  = 98,
  parameter int PAL_GATE_LEN  = 44,
  parameter int PAL_HMIN      = 72,
  parameter int PAL_HMAX      = 94
) (
  input  logic clk,
  input  logic rst,
  input  logic std_pal,
  input  logic hsync_in,
  input  logic vsync_in,
  output logic csync_out,
  output logic burst_gate,
  output logic vblank_mode,
  output logic gate_end
);
  localparam logic [CW-1:0] N_DLY = CW'(NTSC_GATE_DLY);
  localparam logic [CW-1:0] N_LEN = CW'(NTSC_GATE_LEN);
  localparam logic [CW-1:0] N_MIN = CW'(NTSC_HMIN);
  localparam logic [CW-1:0] N_MAX = CW'(NTSC_HMAX);
  localparam logic [CW-1:0] P_DLY = CW'(PAL_GATE_DLY);
  localparam logic [CW-1:0] P_LEN = CW'(PAL_GATE_LEN);
  localparam logic [CW-1:0] P_MIN = CW'(PAL_HMIN);
  localparam logic [CW-1:0] P_MAX = CW'(PAL_HMAX);

  logic [CW-1:0] dly, len, hmin, hmax;
  logic cs, fall, rise, line_p, vblank, gate, gend;

  assign dly  = std_pal ? P_DLY : N_DLY;
  assign len  = std_pal ? P_LEN : N_LEN;
  assign hmin = std_pal ? P_MIN : N_MIN;
  assign hmax = std_pal ? P_MAX : N_MAX;

  vsg_sync_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .hsync_i(hsync_in), .vsync_i(vsync_in),
    .cs_o(cs), .fall_o(fall), .rise_o(rise)
  );

  vsg_width_meas #(.CW(CW)) u_meas (
    .clk(clk), .rst(rst), .cs_i(cs), .fall_i(fall), .rise_i(rise),
    .hmin_i(hmin), .hmax_i(hmax), .line_p_o(line_p), .vblank_o(vblank)
  );

  vsg_gate_timer #(.CW(CW)) u_gate (
    .clk(clk), .rst(rst), .fall_i(fall), .line_p_i(line_p),
    .dly_i(dly), .len_i(len), .gate_o(gate), .end_o(gend)
  );

  assign csync_out   = cs;
  assign burst_gate  = gate;
  assign vblank_mode = vblank;
  assign gate_end    = gend;

  // The gate only opens after a line pulse has ended and cleared the flag.
  assert_gate_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_gate) |-> (csync_out && !vblank_mode));
endmodule

// File: tb/vsync_gate_ctl_tb_top.sv
`timescale 1ns/1ps
module vsync_gate_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_pal = 1'b0;
  logic hs = 1'b1, vs = 1'b1;
  logic csync_out, burst_gate, vblank_mode, gate_end;

  always #2.5 clk = ~clk;

  vsync_gate_ctl dut_i (
    .clk(clk), .rst(rst), .std_pal(std_pal), .hsync_in(hs), .vsync_in(vs),
    .csync_out(csync_out), .burst_gate(burst_gate),
    .vblank_mode(vblank_mode), .gate_end(gate_end)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit exp_vb = 0;

  function automatic int f_dly(bit p);  return p ? 98 : 79; endfunction
  function automatic int f_len(bit p);  return p ? 44 : 36; endfunction
  function automatic int f_hmin(bit p); return p ? 72 : 58; endfunction
  function automatic int f_hmax(bit p); return p ? 94 : 76; endfunction
  // 0 glitch, 1 line, 2 field
  function automatic int f_class(int w, bit p);
    if (w < f_hmin(p)) return 0;
    if (w > f_hmax(p)) return 2;
    return 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor, sampled on the falling clock edge.
  int cyc = 0, last_chg = -1, fall_cyc = 0, width = -1;
  int g_rise = 0, g_fall = -1, g_len = -1, end_cyc = -1, end_cnt = 0;
  bit gate_seen = 0, prev_cs = 1, prev_g = 0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; last_chg = -1; prev_cs = 1; prev_g = 0;
    end else begin
      cyc++;
      if (csync_out !== prev_cs) begin
        if (last_chg >= 0)
          chk(((cyc - last_chg) % 2) == 0, "R3 edge spacing parity", cyc - last_chg, 0);
        last_chg = cyc;
        if (!csync_out) fall_cyc = cyc;
        else width = cyc - fall_cyc;
      end
      if (burst_gate && !prev_g) begin g_rise = cyc; gate_seen = 1; end
      if (!burst_gate && prev_g) begin g_fall = cyc; g_len = cyc - g_rise; end
      if (gate_end) begin end_cnt++; end_cyc = cyc; end
      prev_cs = csync_out;
      prev_g  = burst_gate;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_line(int low, bit via_v, bit p);
    string rq;
    int cls;
    std_pal = p;
    step(4);
    gate_seen = 0; g_fall = -1; g_len = -1; end_cyc = -1; end_cnt = 0; width = -1;
    if (via_v) begin hs = 1; vs = 0; end else begin hs = 0; vs = 1; end
    step(low);
    hs = 1; vs = 1;
    step(f_dly(p) + f_len(p) + 60);
    rq = p ? "R10" : "R4";
    chk(width == low, "R3 output low width", width, low);
    cls = f_class(width, p);
    if (cls == 1) begin
      chk(gate_seen, {rq, " gate opened"}, gate_seen, 1);
      chk(g_rise - fall_cyc == f_dly(p), {rq, " gate delay"}, g_rise - fall_cyc, f_dly(p));
      chk(g_len == f_len(p), "R5 gate length", g_len, f_len(p));
      chk(end_cnt == 1 && end_cyc == g_fall, "R6 gate_end cycle", end_cyc, g_fall);
      chk(vblank_mode == 0, "R9 vblank cleared", vblank_mode, 0);
      exp_vb = 0;
    end else if (cls == 2) begin
      chk(!gate_seen, "R7 no gate on long pulse", gate_seen, 0);
      chk(vblank_mode == 1, "R7 vblank set", vblank_mode, 1);
      exp_vb = 1;
    end else begin
      chk(!gate_seen, "R8 no gate on short pulse", gate_seen, 0);
      chk(vblank_mode == exp_vb, "R8 vblank unchanged", vblank_mode, exp_vb);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    rst = 1; hs = 1; vs = 1;
    step(3);
    chk(csync_out == 1 && burst_gate == 0 && vblank_mode == 0 && gate_end == 0,
        "R1 outputs in reset", {csync_out, burst_gate, vblank_mode, gate_end}, 4'b1000);
    rst = 0;
    step(1);
    chk(csync_out == 1 && burst_gate == 0 && vblank_mode == 0 && gate_end == 0,
        "R1 outputs after reset", {csync_out, burst_gate, vblank_mode, gate_end}, 4'b1000);

    // R2: XNOR merge, all four input combinations
    for (int k = 0; k < 4; k++) begin
      hs = k[0]; vs = k[1];
      step(8);
      chk(csync_out == ~(hs ^ vs), "R2 xnor merge", csync_out, ~(hs ^ vs));
      hs = 1; vs = 1;
      step(8);
    end
    chk(vblank_mode == 0, "R8 vblank after glitches", vblank_mode, 0);

    // Directed boundary widths, both standards, both input paths
    do_line(56, 0, 0);  do_line(58, 0, 0);  do_line(76, 1, 0);
    do_line(78, 0, 0);  do_line(56, 0, 0);  do_line(58, 1, 0);
    do_line(400, 1, 0); do_line(70, 0, 1);  do_line(72, 0, 1);
    do_line(94, 1, 1);  do_line(96, 1, 1);  do_line(94, 0, 1);
    do_line(1100, 1, 1); do_line(20, 0, 1); do_line(76, 0, 0);

    // Constrained random lines
    for (int i = 0; i < 40; i++) begin
      int r, lo;
      bit p, v;
      r = $urandom % 4;
      p = $urandom % 2;
      v = $urandom % 2;
      if (r == 0)      lo = 2 + 2 * ($urandom % ((f_hmin(p) - 2) / 2));
      else if (r == 3) lo = f_hmax(p) + 2 + 2 * ($urandom % 150);
      else             lo = f_hmin(p) + 2 * ($urandom % ((f_hmax(p) - f_hmin(p)) / 2 + 1));
      do_line(lo, v, p);
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule